// File: doc/BRIEF.md
# Programmable Memory Block Mover

This block is a byte-wide DMA engine that a processor sets up through seventeen byte registers and then leaves to run. It either copies bytes from a source region to a destination region, or writes one constant byte across the destination. The region is either a linear run of bytes or a rectangle cut out of a larger image, where each row of source and destination advances by its own stride.

A transfer begins when the control byte is written with both its enable and its start bits set. From the next cycle until the last memory handshake, the halt output holds the processor stopped. A copy makes one read and then one write per byte. A fill makes writes only. Two path bits pick which side of the transfer sits in video RAM, and that side is flagged on every access. At the end of a transfer the block can pulse an interrupt. A size of zero, an access past the top of the 24-bit space, or video RAM that stalls too long each sets a bit in the status byte, which is read back at the same offset where the fill byte is written.

Top module: `mem_dma_ctrl`

## Requirements
- R1: Register offsets: 0x00 is control 0, 0x01 is control 1, 0x02-0x04 is the source address (low byte first), 0x05-0x07 is the destination address, 0x08-0x0B is the size, 0x0C-0x0D is the source stride and 0x0E-0x0F is the destination stride. Each of these reads back what was last written to it. Reset clears all of them.
- R2: Linear copy (control 0 bit 1 = 0, bit 2 = 0) uses size bytes 0-2 as a byte count N. For i = 0 to N-1 in ascending order it reads source+i and then writes that data to destination+i.
- R3: Rectangular mode (bit 1 = 1) takes width W from size bytes 0-1 and height H from size bytes 2-3. Row r, column c reads source + r*source_stride + c and writes destination + r*destination_stride + c, with rows in order and columns in order within each row.
- R4: Fill (bit 2 = 1) writes the byte last stored at offset 0x10 to every destination address and makes no reads.
- R5: halt_o rises on the cycle after the starting write and stays high until the final handshake. Every memory request occurs while halt_o is high. Register writes made while the block is busy have no effect.
- R6: Control 0 bit 7 (start) reads as 1 while a transfer runs and clears when it ends. irq_o pulses for one cycle after a successful completion only if bit 3 is set.
- R7: A start with a byte count of zero, or with a width or height of zero in rectangular mode, sets status bit 0. It makes no memory request, does not raise halt_o, and clears the start bit.
- R8: Path bits 5:4 set mem_vram_o. Value 01 (bit 4 = 1) puts the destination in video RAM, 10 (bit 5 = 1) puts the source in video RAM, and 00 or 11 flags no access.
- R9: On a video RAM access, once mem_ready_i has been low for 256 cycles, a further low cycle aborts the transfer. The abort sets status bit 3, drops halt_o and gives no interrupt. Ready arriving on the 257th cycle completes normally.
- R10: An access whose address would pass 0xFFFFFF is not issued. The transfer aborts with status bit 2 (source) or bit 1 (destination) set, and without an interrupt.
- R11: Reading offset 0x10 returns the status in bits 3:0, not the fill byte. Every accepted start clears the previous status bits.
- R12: A request is held with a stable address until mem_ready_i is seen high.
- R13: Writing the start bit with the enable bit (control 0 bit 0) clear starts nothing, and the start bit reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_vram_o | output | 1 | Access targets video RAM |
| mem_addr_o | output | 24 | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid with ready |
| mem_ready_i | input | 1 | Access completes this cycle |
| halt_o | output | 1 | Processor halt |
| irq_o | output | 1 | End-of-transfer interrupt pulse |

## Verification
The bound checker watches, on every cycle, that requests only appear under halt, that a waiting request keeps its address, that the interrupt is a single-cycle pulse right after halt drops, and that the start bit is clear whenever halt falls. The address order of the linear and rectangular walks, the data carried from read to write, the fill byte, the path flags, the status codes and the exact 256-cycle timeout limit can only be shown by the bench's scoreboard scenarios against its memory model.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int ADDR_W     = 24;
  localparam int DIM_W      = 16;
  localparam int STRIDE_W   = 16;
  localparam int BANK_BYTES = 16;

  localparam logic [4:0] OFF_CTRL0 = 5'h00;
  localparam logic [4:0] OFF_FILL  = 5'h10;

  localparam int C_EN    = 0;
  localparam int C_RECT  = 1;
  localparam int C_FILL  = 2;
  localparam int C_IE    = 3;
  localparam int C_SSYS  = 4;
  localparam int C_DSYS  = 5;
  localparam int C_START = 7;

  localparam int S_SIZE = 0;
  localparam int S_DST  = 1;
  localparam int S_SRC  = 2;
  localparam int S_TOUT = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} dma_state_e;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_we_i,
  input  logic [4:0]              reg_addr_i,
  input  logic [7:0]              reg_wdata_i,
  output logic [7:0]              reg_rdata_o,
  input  logic                    busy_i,
  input  logic                    clr_start_i,
  input  logic [3:0]              status_i,
  output logic                    go_o,
  output logic [7:0]              ctrl0_o,
  output logic [ADDR_W-1:0]       src_o,
  output logic [ADDR_W-1:0]       dst_o,
  output logic [2*DIM_W-1:0]      size_o,
  output logic [STRIDE_W-1:0]     sstride_o,
  output logic [STRIDE_W-1:0]     dstride_o,
  output logic [7:0]              fill_o
);
  logic [7:0] bank_q [BANK_BYTES];
  logic [7:0] fill_q;
  logic       go_q;
  logic       wr_ok;
  logic       start_wr;

  assign wr_ok    = reg_we_i && !busy_i && !go_q;
  assign start_wr = reg_wdata_i[C_START] && reg_wdata_i[C_EN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BANK_BYTES; i++) bank_q[i] <= '0;
      fill_q <= '0;
      go_q   <= 1'b0;
    end else begin
      go_q <= wr_ok && (reg_addr_i == OFF_CTRL0) && start_wr;
      if (wr_ok && !reg_addr_i[4]) begin
        if (reg_addr_i == OFF_CTRL0) bank_q[0] <= {start_wr, reg_wdata_i[6:0]};
        else bank_q[reg_addr_i[3:0]] <= reg_wdata_i;
      end
      if (wr_ok && reg_addr_i == OFF_FILL) fill_q <= reg_wdata_i;
      if (clr_start_i) bank_q[0][C_START] <= 1'b0;
    end
  end

  always_comb begin
    if (!reg_addr_i[4])             reg_rdata_o = bank_q[reg_addr_i[3:0]];
    else if (reg_addr_i == OFF_FILL) reg_rdata_o = {4'b0, status_i};
    else                            reg_rdata_o = '0;
  end

  assign go_o      = go_q;
  assign ctrl0_o   = bank_q[0];
  assign src_o     = {bank_q[4], bank_q[3], bank_q[2]};
  assign dst_o     = {bank_q[7], bank_q[6], bank_q[5]};
  assign size_o    = {bank_q[11], bank_q[10], bank_q[9], bank_q[8]};
  assign sstride_o = {bank_q[13], bank_q[12]};
  assign dstride_o = {bank_q[15], bank_q[14]};
  assign fill_o    = fill_q;
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int ADDR_W   = 24,
  parameter int LEN_W    = 24,
  parameter int ROW_W    = 16,
  parameter int STRIDE_W = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic                        step_i,
  input  logic [1:0][ADDR_W-1:0]      base_i,
  input  logic [1:0][STRIDE_W-1:0]    stride_i,
  input  logic [LEN_W-1:0]            row_len_i,
  input  logic [ROW_W-1:0]            rows_i,
  output logic [1:0][ADDR_W-1:0]      addr_o,
  output logic [1:0]                  err_o,
  output logic                        last_o
);
  logic [LEN_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic             last_col;

  assign last_col = (col_q == row_len_i - LEN_W'(1));
  assign last_o   = last_col && (row_q == rows_i - ROW_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else if (load_i) begin
      col_q <= '0;
      row_q <= '0;
    end else if (step_i) begin
      if (last_col) begin
        col_q <= '0;
        row_q <= row_q + ROW_W'(1);
      end else begin
        col_q <= col_q + LEN_W'(1);
      end
    end
  end

  // index 0 = source, 1 = destination; top bit of a row base is sticky carry
  for (genvar g = 0; g < 2; g++) begin : g_chan
    logic [ADDR_W:0] row_base_q;
    logic [ADDR_W:0] next_base;
    logic [ADDR_W:0] cur_sum;

    assign next_base = {1'b0, row_base_q[ADDR_W-1:0]} + (ADDR_W+1)'(stride_i[g]);
    assign cur_sum   = {1'b0, row_base_q[ADDR_W-1:0]} + (ADDR_W+1)'(col_q);
    assign addr_o[g] = cur_sum[ADDR_W-1:0];
    assign err_o[g]  = row_base_q[ADDR_W] | cur_sum[ADDR_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) row_base_q <= '0;
      else if (load_i) row_base_q <= {1'b0, base_i[g]};
      else if (step_i && last_col)
        row_base_q <= {row_base_q[ADDR_W] | next_base[ADDR_W], next_base[ADDR_W-1:0]};
    end
  end
endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
  import dma_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] ctrl0_i,
  input  logic       size_zero_i,
  input  logic [1:0] addr_err_i,
  input  logic       last_i,
  input  logic [7:0] mem_rdata_i,
  input  logic       mem_ready_i,
  output logic       mem_req_o,
  output logic       mem_we_o,
  output logic       mem_vram_o,
  output logic       rd_phase_o,
  output logic [7:0] data_o,
  output logic       halt_o,
  output logic       irq_o,
  output logic       clr_start_o,
  output logic       gen_load_o,
  output logic       gen_step_o,
  output logic [3:0] status_o
);
  localparam int WAIT_W = $clog2(TIMEOUT_CYCLES + 1);

  dma_state_e      state_q;
  logic [WAIT_W-1:0] wait_q;
  logic [7:0]      data_q;
  logic [3:0]      status_q;
  logic            irq_q;
  logic            src_vram, dst_vram, cur_err, hs, stalled, tout, done;

  assign src_vram   = !ctrl0_i[C_SSYS] &&  ctrl0_i[C_DSYS];
  assign dst_vram   =  ctrl0_i[C_SSYS] && !ctrl0_i[C_DSYS];
  assign rd_phase_o = (state_q == ST_RD);
  assign cur_err    = (state_q == ST_RD) ? addr_err_i[0] :
                      (state_q == ST_WR) ? addr_err_i[1] : 1'b0;
  assign mem_req_o  = (state_q != ST_IDLE) && !cur_err;
  assign mem_we_o   = (state_q == ST_WR);
  assign mem_vram_o = mem_req_o && (rd_phase_o ? src_vram : dst_vram);
  assign hs         = mem_req_o && mem_ready_i;
  assign stalled    = mem_vram_o && !mem_ready_i;
  assign tout       = stalled && (wait_q == WAIT_W'(TIMEOUT_CYCLES));
  assign done       = hs && (state_q == ST_WR) && last_i;

  assign gen_load_o  = go_i && (state_q == ST_IDLE);
  assign gen_step_o  = hs && (state_q == ST_WR);
  assign clr_start_o = (gen_load_o && size_zero_i) || cur_err || tout || done;
  assign halt_o      = (state_q != ST_IDLE);
  assign irq_o       = irq_q;
  assign data_o      = data_q;
  assign status_o    = status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      wait_q   <= '0;
      data_q   <= '0;
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      irq_q  <= 1'b0;
      wait_q <= (stalled && !tout) ? wait_q + WAIT_W'(1) : '0;
      case (state_q)
        ST_IDLE: if (go_i) begin
          status_q <= size_zero_i ? 4'(1 << S_SIZE) : 4'b0;
          if (!size_zero_i) state_q <= ctrl0_i[C_FILL] ? ST_WR : ST_RD;
        end
        default: begin
          if (cur_err) begin
            status_q[rd_phase_o ? S_SRC : S_DST] <= 1'b1;
            state_q <= ST_IDLE;
          end else if (tout) begin
            status_q[S_TOUT] <= 1'b1;
            state_q <= ST_IDLE;
          end else if (hs) begin
            if (state_q == ST_RD) begin
              data_q  <= mem_rdata_i;
              state_q <= ST_WR;
            end else if (last_i) begin
              irq_q   <= ctrl0_i[C_IE];
              state_q <= ST_IDLE;
            end else begin
              state_q <= ctrl0_i[C_FILL] ? ST_WR : ST_RD;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mem_dma_ctrl.sv
module mem_dma_ctrl
  import dma_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [4:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_vram_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              halt_o,
  output logic              irq_o
);
  localparam int LEN_W = ADDR_W;

  logic                      go, clr_start, gen_load, gen_step, last, rd_phase;
  logic [7:0]                ctrl0, fill, data;
  logic [3:0]                status;
  logic [ADDR_W-1:0]         src, dst;
  logic [2*DIM_W-1:0]        size;
  logic [STRIDE_W-1:0]       sstride, dstride;
  logic [LEN_W-1:0]          row_len;
  logic [DIM_W-1:0]          rows;
  logic [1:0][ADDR_W-1:0]    addrs;
  logic [1:0]                addr_err;
  logic                      size_zero;

  assign row_len   = ctrl0[C_RECT] ? LEN_W'(size[DIM_W-1:0]) : size[LEN_W-1:0];
  assign rows      = ctrl0[C_RECT] ? size[2*DIM_W-1:DIM_W] : DIM_W'(1);
  assign size_zero = (row_len == '0) || (rows == '0);

  dma_regs u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(halt_o), .clr_start_i(clr_start), .status_i(status),
    .go_o(go), .ctrl0_o(ctrl0), .src_o(src), .dst_o(dst), .size_o(size),
    .sstride_o(sstride), .dstride_o(dstride), .fill_o(fill)
  );

  dma_addr_gen #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ROW_W(DIM_W), .STRIDE_W(STRIDE_W)
  ) u_gen (
    .clk_i, .rst_ni, .load_i(gen_load), .step_i(gen_step),
    .base_i({dst, src}), .stride_i({dstride, sstride}),
    .row_len_i(row_len), .rows_i(rows),
    .addr_o(addrs), .err_o(addr_err), .last_o(last)
  );

  dma_fsm #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_fsm (
    .clk_i, .rst_ni, .go_i(go), .ctrl0_i(ctrl0), .size_zero_i(size_zero),
    .addr_err_i(addr_err), .last_i(last), .mem_rdata_i, .mem_ready_i,
    .mem_req_o, .mem_we_o, .mem_vram_o, .rd_phase_o(rd_phase), .data_o(data),
    .halt_o, .irq_o, .clr_start_o(clr_start), .gen_load_o(gen_load),
    .gen_step_o(gen_step), .status_o(status)
  );

  assign mem_addr_o  = rd_phase ? addrs[0] : addrs[1];
  assign mem_wdata_o = ctrl0[C_FILL] ? fill : data;
endmodule

// File: rtl/mem_dma_ctrl_chk.sv
module mem_dma_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        halt_o,
  input logic        irq_o,
  input logic        mem_req_o,
  input logic        mem_ready_i,
  input logic        mem_vram_o,
  input logic [23:0] mem_addr_o,
  input logic [7:0]  ctrl0
);
  // R5
  req_in_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> halt_o);
  // R6
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R6
  irq_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!halt_o && $past(halt_o)));
  // R12
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i && !mem_vram_o) |=> (mem_req_o && $stable(mem_addr_o)));
  // R6
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halt_o) |-> !ctrl0[7]);
endmodule

bind mem_dma_ctrl mem_dma_ctrl_chk u_chk (
  .clk_i, .rst_ni, .halt_o, .irq_o, .mem_req_o, .mem_ready_i,
  .mem_vram_o, .mem_addr_o, .ctrl0
);

// File: tb/mem_dma_ctrl_bench.sv
`timescale 1ns/1ps
module mem_dma_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_vram, halt, irq;
  logic [23:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = '0;
  logic mem_ready = 1'b0;

  always #2.5 clk = ~clk;

  mem_dma_ctrl u_mem_dma_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_vram_o(mem_vram), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready),
    .halt_o(halt), .irq_o(irq)
  );

  typedef struct packed { logic we; logic vram; logic [23:0] addr; logic [7:0] data; } op_t;
  op_t exp_q[$];
  int checks = 0, errors = 0, irq_cnt = 0, halt_cnt = 0, st_cnt = 0;
  int sys_stall = 0, vram_stall = 0;
  string cur_tag = "R2";

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (halt) halt_cnt++;
    if (!mem_req) begin
      mem_ready = 1'b0;
      st_cnt = 0;
    end else begin
      mem_rdata = pat(mem_addr);
      mem_ready = (st_cnt >= (mem_vram ? vram_stall : sys_stall));
      if (mem_ready) begin
        st_cnt = 0;
        if (exp_q.size() == 0) check({cur_tag, " unexpected access"}, {7'b0, mem_we, mem_addr}, 32'hFFFFFFFF);
        else begin
          op_t e;
          e = exp_q.pop_front();
          check({cur_tag, " op kind/addr"}, {6'b0, mem_vram, mem_we, mem_addr}, {6'b0, e.vram, e.we, e.addr});
          if (e.we) check({cur_tag, " write data"}, {24'b0, mem_wdata}, {24'b0, e.data});
        end
      end else st_cnt++;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic prog(input logic [23:0] s, input logic [23:0] d, input logic [31:0] sz,
                      input logic [15:0] ss, input logic [15:0] ds, input logic [7:0] f);
    for (int i = 0; i < 3; i++) wr(5'(2 + i), s[8*i +: 8]);
    for (int i = 0; i < 3; i++) wr(5'(5 + i), d[8*i +: 8]);
    for (int i = 0; i < 4; i++) wr(5'(8 + i), sz[8*i +: 8]);
    wr(5'd12, ss[7:0]); wr(5'd13, ss[15:8]);
    wr(5'd14, ds[7:0]); wr(5'd15, ds[15:8]);
    wr(5'd16, f);
  endtask

  task automatic push(input logic we, input logic v, input logic [23:0] a, input logic [7:0] d);
    op_t o;
    o.we = we; o.vram = v; o.addr = a; o.data = d;
    exp_q.push_back(o);
  endtask

  task automatic run(input logic [7:0] c0, output int cyc);
    wr(5'd0, c0);
    cyc = 0;
    @(negedge clk);
    while (halt && cyc < 2000) begin @(negedge clk); cyc++; end
    @(negedge clk);
  endtask

  logic [7:0] rv;
  int cyc, irq0, h0;

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    check("R5 halt after reset", {31'b0, halt}, 0);
    check("R6 irq after reset", {31'b0, irq}, 0);
    rd(5'd16, rv); check("R11 status after reset", rv, 0);
    rd(5'd3, rv);  check("R1 reset src mid", rv, 0);

    // register readback
    cur_tag = "R1";
    prog(24'h123456, 24'h789ABC, 32'h0000_0005, 16'h0102, 16'h0304, 8'hC3);
    wr(5'd1, 8'h3C);
    rd(5'd1, rv);  check("R1 ctrl1", rv, 8'h3C);
    rd(5'd2, rv);  check("R1 src lo", rv, 8'h56);
    rd(5'd7, rv);  check("R1 dst hi", rv, 8'h78);
    rd(5'd8, rv);  check("R1 size b0", rv, 8'h05);
    rd(5'd15, rv); check("R1 dstride hi", rv, 8'h03);
    rd(5'd16, rv); check("R11 fill offset reads status", rv, 8'h00);

    // linear copy sys->sys, irq enabled
    cur_tag = "R2";
    prog(24'h001000, 24'h002000, 32'd5, 16'd0, 16'd0, 8'h00);
    for (int i = 0; i < 5; i++) begin
      push(1'b0, 1'b0, 24'h001000 + 24'(i), 8'h00);
      push(1'b1, 1'b0, 24'h002000 + 24'(i), pat(24'h001000 + 24'(i)));
    end
    irq0 = irq_cnt;
    run(8'h89, cyc);
    check("R2 all ops done", exp_q.size(), 0);
    check("R6 irq once", irq_cnt - irq0, 1);
    check("R5 halt length", cyc, 10);
    rd(5'd0, rv); check("R6 start cleared", rv, 8'h09);

    // rectangular copy, source in video RAM (path bit 5)
    cur_tag = "R3 R8";
    prog(24'h004000, 24'h005000, {16'd2, 16'd3}, 16'd8, 16'd16, 8'h00);
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 3; c++) begin
        push(1'b0, 1'b1, 24'h004000 + 24'(r*8 + c), 8'h00);
        push(1'b1, 1'b0, 24'h005000 + 24'(r*16 + c), pat(24'h004000 + 24'(r*8 + c)));
      end
    irq0 = irq_cnt;
    run(8'hA3, cyc);
    check("R3 all ops done", exp_q.size(), 0);
    check("R6 irq off when disabled", irq_cnt - irq0, 0);

    // rectangular fill, destination in video RAM (path bit 4)
    cur_tag = "R4 R8";
    prog(24'h000000, 24'h006000, {16'd3, 16'd2}, 16'd0, 16'd5, 8'hA7);
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 2; c++) push(1'b1, 1'b1, 24'h006000 + 24'(r*5 + c), 8'hA7);
    run(8'h97, cyc);
    check("R4 fill ops done", exp_q.size(), 0);

    // size errors
    cur_tag = "R7";
    prog(24'h001000, 24'h002000, 32'd0, 16'd0, 16'd0, 8'h00);
    h0 = halt_cnt;
    run(8'h81, cyc);
    rd(5'd16, rv); check("R7 linear zero status", rv, 8'h01);
    check("R7 no halt", halt_cnt - h0, 0);
    rd(5'd0, rv);  check("R7 start cleared", rv, 8'h01);
    prog(24'h001000, 24'h002000, {16'd0, 16'd4}, 16'd4, 16'd4, 8'h00);
    run(8'h83, cyc);
    rd(5'd16, rv); check("R7 zero height status", rv, 8'h01);
    check("R7 no halt rect", halt_cnt - h0, 0);

    // stalled linear copy, status cleared on new start
    cur_tag = "R12 R11";
    sys_stall = 3;
    prog(24'h00A000, 24'h00B000, 32'd3, 16'd0, 16'd0, 8'h00);
    for (int i = 0; i < 3; i++) begin
      push(1'b0, 1'b0, 24'h00A000 + 24'(i), 8'h00);
      push(1'b1, 1'b0, 24'h00B000 + 24'(i), pat(24'h00A000 + 24'(i)));
    end
    run(8'h81, cyc);
    sys_stall = 0;
    check("R12 stalled ops done", exp_q.size(), 0);
    rd(5'd16, rv); check("R11 status cleared", rv, 8'h00);

    // video RAM wait of exactly 256 cycles completes
    cur_tag = "R9";
    vram_stall = 256;
    prog(24'h000000, 24'h007000, 32'd1, 16'd0, 16'd0, 8'h3E);
    push(1'b1, 1'b1, 24'h007000, 8'h3E);
    irq0 = irq_cnt;
    run(8'h9D, cyc);
    check("R9 256 low cycles ok", exp_q.size(), 0);
    rd(5'd16, rv); check("R9 no timeout at limit", rv, 8'h00);
    check("R9 irq on completion", irq_cnt - irq0, 1);

    // timeout abort; register write while busy is ignored
    vram_stall = 1000;
    prog(24'h0000AA, 24'h008000, 32'd2, 16'd0, 16'd0, 8'h11);
    irq0 = irq_cnt;
    wr(5'd0, 8'h9D);
    wr(5'd2, 8'hEE);
    cyc = 0;
    while (halt && cyc < 2000) begin @(negedge clk); cyc++; end
    @(negedge clk);
    vram_stall = 0;
    rd(5'd16, rv); check("R9 timeout status", rv, 8'h08);
    check("R9 halt released", {31'b0, halt}, 0);
    check("R9 no irq on abort", irq_cnt - irq0, 0);
    check("R9 abort time bounded", {31'b0, (cyc > 240 && cyc < 300)}, 1);
    rd(5'd2, rv);  check("R5 busy write ignored", rv, 8'hAA);
    check("R9 nothing acked", exp_q.size(), 0);

    // address overflow, source side
    cur_tag = "R10";
    prog(24'hFFFFFE, 24'h000100, 32'd4, 16'd0, 16'd0, 8'h00);
    for (int i = 0; i < 2; i++) begin
      push(1'b0, 1'b0, 24'hFFFFFE + 24'(i), 8'h00);
      push(1'b1, 1'b0, 24'h000100 + 24'(i), pat(24'hFFFFFE + 24'(i)));
    end
    irq0 = irq_cnt;
    run(8'h89, cyc);
    check("R10 src ops before abort", exp_q.size(), 0);
    rd(5'd16, rv); check("R10 src error status", rv, 8'h04);
    check("R10 no irq", irq_cnt - irq0, 0);
    // destination side
    prog(24'h000000, 24'hFFFFFF, 32'd3, 16'd0, 16'd0, 8'h42);
    push(1'b1, 1'b0, 24'hFFFFFF, 8'h42);
    run(8'h85, cyc);
    check("R10 dst ops before abort", exp_q.size(), 0);
    rd(5'd16, rv); check("R10 dst error status", rv, 8'h02);

    // start without enable
    cur_tag = "R13";
    prog(24'h001000, 24'h002000, 32'd2, 16'd0, 16'd0, 8'h00);
    h0 = halt_cnt;
    run(8'h80, cyc);
    check("R13 no halt", halt_cnt - h0, 0);
    rd(5'd0, rv); check("R13 start reads 0", rv, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule